// File: doc/BRIEF.md
# Three-Phase Sine Reference Generator

This block produces three sine reference samples for a multilevel PWM modulator. The three phases are 120 degrees apart. One table of sampled sine values serves all three phases. Phase A reads at a base index, and phases B and C read at the base plus one third and plus two thirds of the table length. Each output is an unsigned sample in the same range as a 9-bit triangle carrier, so a modulator can compare it with its carriers directly.

The table holds one full sine cycle. Its contents are fixed when the design is elaborated. The base index moves only when the update strobe is high, and it moves by the step input. A step larger than one skips table entries, which raises the output frequency. The amplitude and the midpoint are parameters of the table.

Top module: `sine3_ref_gen`

## Requirements
- R1: A synchronous active-low reset sets the base index to 0 and the three outputs to 0.
- R2: For table index i, phase A gives round(256 + 255*sin(2*pi*i/384)) to within 1 LSB. The defaults are TABLE_LEN=384, MID=256 and AMP=255.
- R3: On each clock edge where `upd_stb` is 1, the base index becomes (base + step) mod 384. A step of 384 or more is first reduced modulo 384.
- R4: On a clock edge where `upd_stb` is 0, the base index and the outputs stay unchanged, whatever the value of `step`.
- R5: Phase B reads table index (base + 128) mod 384, which is the +120 degree offset.
- R6: Phase C reads table index (base + 256) mod 384, which is the -120 degree offset.
- R7: The outputs are registered. After the edge that updates the base index, they change on the next clock edge.
- R8: Outside reset, every sample lies in [MID-AMP, MID+AMP]. The sum of the three samples stays within 3 of 3*MID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_stb | input | 1 | Advances the base index by `step` |
| step | input | 9 | Number of table entries to advance per update |
| ref_a | output | 9 | Phase A sample, unsigned |
| ref_b | output | 9 | Phase B sample, unsigned |
| ref_c | output | 9 | Phase C sample, unsigned |

## Verification
The bench walks the base index with a step of 1 through a full cycle, so every table entry is seen on all three phases. A table built with the wrong sign, the wrong quadrant or the wrong rounding shows up as a sample more than 1 LSB from the ideal sine. It also applies steps of 0, 383, 500 and 7. A design that wraps without a modulo, or that ignores the reduction of an over-range step, ends up at the wrong index and then diverges on every update that follows. The bench checks the outputs on the cycle right after an update and requires the old values there, which catches a missing or extra register stage. It also changes `step` while the strobe is low and checks that nothing moves. Off-by-one phase offsets break both the per-phase checks and the three-phase sum.

// File: rtl/sinegen_pkg.sv
// Package: shared sample arithmetic for the sine reference generator.
// Assumes the table length is even and small enough for 64-bit products.
package sinegen_pkg;

    // Integer sine sample using the Bhaskara rational approximation per half cycle.
    function automatic int sine_sample(int i, int len, int mid, int amp);
        longint half, pos, q, num, den, mag;
        half = longint'(len / 2);
        pos  = (i < len / 2) ? longint'(i) : longint'(i) - half;
        q    = pos * (half - pos);
        num  = 16 * q * longint'(amp);
        den  = 5 * half * half - 4 * q;
        mag  = (2 * num + den) / (2 * den);
        return (i < len / 2) ? mid + int'(mag) : mid - int'(mag);
    endfunction

endpackage

// File: rtl/phase_accum.sv
// Module: phase_accum
// Holds the base table index. On each update strobe it adds the step, with the
// step first reduced modulo TABLE_LEN and the sum wrapped into 0..TABLE_LEN-1.
// Assumes IDX_W can hold TABLE_LEN-1.
module phase_accum #(
    parameter int TABLE_LEN = 384,
    parameter int IDX_W     = 9,
    parameter int STEP_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_stb,
    input  logic [STEP_W-1:0] step,
    output logic [IDX_W-1:0]  base
);
    localparam int SUM_W = ((IDX_W > STEP_W) ? IDX_W : STEP_W) + 1;

    logic [SUM_W-1:0] step_red;
    logic [SUM_W-1:0] sum;
    logic [IDX_W-1:0] base_next;

    // Reduce the step into range and form the wrapped next index.
    always_comb begin
        step_red  = SUM_W'(step) % SUM_W'(TABLE_LEN);
        sum       = SUM_W'(base) + step_red;
        base_next = (sum >= SUM_W'(TABLE_LEN)) ? IDX_W'(sum - SUM_W'(TABLE_LEN))
                                              : IDX_W'(sum);
    end

    // Base index register: cleared by reset, advanced on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base <= '0;
        else if (upd_stb)
            base <= base_next;
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> base == '0);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_stb |=> $stable(base));

    assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> int'(base) == (int'($past(base)) + int'($past(step))) % TABLE_LEN);

    assert_base_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(base) < TABLE_LEN);

endmodule

// File: rtl/phase_offset.sv
// Module: phase_offset
// Derives one table index per phase. Phase k reads at base + k*TABLE_LEN/PHASES,
// wrapped. Assumes TABLE_LEN is a multiple of PHASES and base < TABLE_LEN.
module phase_offset #(
    parameter int TABLE_LEN = 384,
    parameter int IDX_W     = 9,
    parameter int PHASES    = 3
) (
    input  logic [IDX_W-1:0]             base,
    output logic [PHASES-1:0][IDX_W-1:0] idx
);
    localparam int OFF_W = IDX_W + 1;

    for (genvar ph = 0; ph < PHASES; ph++) begin : g_phase
        localparam int OFFSET = ph * (TABLE_LEN / PHASES);
        logic [OFF_W-1:0] raw;
        // Add this phase's fixed offset and wrap into the table.
        always_comb begin
            raw     = OFF_W'(base) + OFF_W'(OFFSET);
            idx[ph] = (raw >= OFF_W'(TABLE_LEN)) ? IDX_W'(raw - OFF_W'(TABLE_LEN))
                                                : IDX_W'(raw);
        end
    end

endmodule

// File: rtl/sine_rom.sv
// Module: sine_rom
// One sine cycle of TABLE_LEN samples, computed at elaboration, with PORTS
// combinational read ports. Assumes every read index is below TABLE_LEN.
module sine_rom #(
    parameter int TABLE_LEN = 384,
    parameter int IDX_W     = 9,
    parameter int SAMPLE_W  = 9,
    parameter int MID       = 256,
    parameter int AMP       = 255,
    parameter int PORTS     = 3
) (
    input  logic [PORTS-1:0][IDX_W-1:0]    rd_idx,
    output logic [PORTS-1:0][SAMPLE_W-1:0] rd_q
);
    import sinegen_pkg::*;

    logic [SAMPLE_W-1:0] table_q [TABLE_LEN];

    // Each entry is a constant produced from the sample function.
    for (genvar k = 0; k < TABLE_LEN; k++) begin : g_entry
        assign table_q[k] = SAMPLE_W'(sine_sample(k, TABLE_LEN, MID, AMP));
    end

    // Read ports, one per phase.
    for (genvar p = 0; p < PORTS; p++) begin : g_port
        assign rd_q[p] = table_q[rd_idx[p]];
    end

endmodule

// File: rtl/sine3_ref_gen.sv
// Module: sine3_ref_gen (top)
// Three-phase sine reference. A strobed base index addresses one shared table
// at offsets of 0, +120 and -120 degrees. The looked-up samples are registered
// once, so the outputs follow an index update by one clock.
// Assumes TABLE_LEN is a multiple of 3 and MID +/- AMP fits in SAMPLE_W bits.
module sine3_ref_gen #(
    parameter int TABLE_LEN = 384,
    parameter int SAMPLE_W  = 9,
    parameter int STEP_W    = 9,
    parameter int MID       = 256,
    parameter int AMP       = 255
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_stb,
    input  logic [STEP_W-1:0]   step,
    output logic [SAMPLE_W-1:0] ref_a,
    output logic [SAMPLE_W-1:0] ref_b,
    output logic [SAMPLE_W-1:0] ref_c
);
    localparam int IDX_W  = $clog2(TABLE_LEN);
    localparam int PHASES = 3;

    logic [IDX_W-1:0]                base;
    logic [PHASES-1:0][IDX_W-1:0]    idx;
    logic [PHASES-1:0][SAMPLE_W-1:0] rom_q;
    logic [PHASES-1:0][SAMPLE_W-1:0] out_q;

    phase_accum #(.TABLE_LEN(TABLE_LEN), .IDX_W(IDX_W), .STEP_W(STEP_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_stb (upd_stb),
        .step    (step),
        .base    (base)
    );

    phase_offset #(.TABLE_LEN(TABLE_LEN), .IDX_W(IDX_W), .PHASES(PHASES)) u_offset (
        .base (base),
        .idx  (idx)
    );

    sine_rom #(.TABLE_LEN(TABLE_LEN), .IDX_W(IDX_W), .SAMPLE_W(SAMPLE_W),
               .MID(MID), .AMP(AMP), .PORTS(PHASES)) u_rom (
        .rd_idx (idx),
        .rd_q   (rom_q)
    );

    // Output register stage: zero in reset, otherwise the current lookups.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= rom_q;
    end

    assign ref_a = out_q[0];
    assign ref_b = out_q[1];
    assign ref_c = out_q[2];

    assert_reset_out_R1: assert property (@(posedge clk)
        !rst_n |=> (ref_a == '0 && ref_b == '0 && ref_c == '0));

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(upd_stb) && !upd_stb |=> $stable(ref_a) && $stable(ref_b) && $stable(ref_c));

    assert_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (int'(ref_a) >= MID - AMP && int'(ref_a) <= MID + AMP &&
                          int'(ref_b) >= MID - AMP && int'(ref_b) <= MID + AMP &&
                          int'(ref_c) >= MID - AMP && int'(ref_c) <= MID + AMP));

    assert_balanced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (int'(ref_a) + int'(ref_b) + int'(ref_c) <= 3 * MID + 3 &&
                          int'(ref_a) + int'(ref_b) + int'(ref_c) >= 3 * MID - 3));

endmodule

// File: tb/test_sine3_ref_gen.sv
// Bench for sine3_ref_gen: full-cycle sweep, several step sizes, holds and reset.
module test_sine3_ref_gen;
    localparam int CLK_PERIOD = 10;
    localparam int L = 384;
    localparam real PI = 3.14159265358979;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_stb = 1'b0;
    logic [8:0] step = '0;
    logic [8:0] ref_a, ref_b, ref_c;

    int checks = 0;
    int fails = 0;
    int base_m = 0;
    bit done = 0;

    sine3_ref_gen i_sine3_ref_gen (
        .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .step(step),
        .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int ideal(int i);
        real v;
        v = 256.0 + 255.0 * $sin(2.0 * PI * real'(i) / real'(L));
        return $rtoi(v + 0.5);
    endfunction

    task automatic check(string req, int act, int exp, int tol);
        checks++;
        if (act > exp + tol || act < exp - tol) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
        end
    endtask

    // Check all three phases against the model base index.
    task automatic check_phases(int b);
        check("R2 R3 phase A", int'(ref_a), ideal(b), 1);
        check("R5 phase B", int'(ref_b), ideal((b + 128) % L), 1);
        check("R6 phase C", int'(ref_c), ideal((b + 256) % L), 1);
        check("R8 sum", int'(ref_a) + int'(ref_b) + int'(ref_c), 768, 3);
        check("R8 span", (ref_a >= 1 && ref_b >= 1 && ref_c >= 1) ? 1 : 0, 1, 0);
    endtask

    // One strobed update; verifies the one-cycle output latency on the way.
    task automatic do_update(int s);
        int old_b;
        old_b = base_m;
        @(negedge clk);
        upd_stb = 1'b1;
        step = 9'(s);
        @(negedge clk);
        upd_stb = 1'b0;
        base_m = (base_m + s) % L;
        check("R7 old value held one cycle", int'(ref_a), ideal(old_b), 1);
        @(negedge clk);
        check_phases(base_m);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset a", int'(ref_a), 0, 0);
        check("R1 reset b", int'(ref_b), 0, 0);
        check("R1 reset c", int'(ref_c), 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_phases(0);

        // Full sweep with step 1 covers every entry on every phase.
        for (int n = 0; n < L; n++) do_update(1);

        // Skipping entries, zero step, wrap and an over-range step (R3).
        for (int n = 0; n < 60; n++) do_update(7);
        do_update(0);
        for (int n = 0; n < 10; n++) do_update(383);
        for (int n = 0; n < 10; n++) do_update(500);
        for (int n = 0; n < 20; n++) do_update(191);

        // R4: step changes without strobe must not move anything.
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            step = 9'(n * 61 + 3);
            @(negedge clk);
            check_phases(base_m);
        end

        // R1: reset in mid-run returns to index 0.
        @(negedge clk);
        rst_n = 1'b0;
        upd_stb = 1'b1;
        step = 9'd50;
        @(negedge clk);
        check("R1 mid-run reset", int'(ref_a) + int'(ref_b) + int'(ref_c), 0, 0);
        upd_stb = 1'b0;
        rst_n = 1'b1;
        base_m = 0;
        @(negedge clk);
        check_phases(0);
        do_update(96);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule